// File: doc/BRIEF.md
# Operand Address-Mode Classifier

This block sits between instruction fetch and operand access. It takes the six-bit operand specifier of an instruction, split into a three-bit mode and a three-bit register, together with a code for the operand size. From these it works out which addressing form the instruction uses. It reports the register the form refers to and a set of one-hot-style mode flags. It also reports whether the specifier is illegal, and how many 16-bit extension words follow the opcode for this operand. It does not fetch those words or form any address. A separate fetch unit takes the word count, and the indexed-address unit later resolves the full length of the indexed forms.

A request is accepted on a valid/ready handshake. The classification is registered and presented one cycle later with its own valid. The response is held unchanged until downstream signals ready. A new request is accepted in the same cycle that the previous response is consumed, so back-to-back decoding runs at one specifier per cycle.

Top module: `ea_field_decoder`

## Requirements
- R1: The response flags use these bit positions: bit0 register-direct, bit1 immediate, bit2 post-increment, bit3 pre-decrement, bit4 displacement, bit5 indexed, bit6 absolute, bit7 PC-relative. When specifier bits [5:4] are both 0, the response has only bit0 set, the register is specifier bits [3:0], the word count is 0 and illegal is 0.
- R2: Modes 2, 3 and 4 (specifier bits [5:3]) report register 8 plus bits [2:0], with a word count of 0. Mode 2 has no flags, mode 3 has only post-increment, and mode 4 has only pre-decrement.
- R3: Mode 5 reports register 8 plus bits [2:0], the displacement flag only, and 1 extension word, whatever the size code.
- R4: Mode 6 reports register 8 plus bits [2:0], the indexed flag only, and 1 extension word.
- R5: In mode 7 the register output is bits [2:0]. Sub-code 0 is absolute with 1 word, and sub-code 1 is absolute with 2 words.
- R6: Mode 7 sub-code 2 reports PC-relative plus displacement (flags 0x90) with 1 word. Sub-code 3 reports PC-relative plus indexed (flags 0xA0) with 1 word.
- R7: Specifier octal 74 reports only the immediate flag and register 4. Its word count comes from the size code: 0 (byte) gives 1, 1 (word) gives 1, 2 (long) gives 2, 3 (8-byte) gives 4, and 4 (12-byte) gives 6.
- R8: Mode 7 sub-codes 5, 6 and 7 report illegal=1. So does octal 74 with a size code of 5 to 7. An illegal response carries flags 0 and a word count of 0.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request produces `rsp_valid=1` with its result on the next cycle.
- R10: While `rsp_valid=1` and `rsp_ready=0`, the response fields and `rsp_valid` stay unchanged, and presented requests are not accepted.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decode request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_field | input | 6 | Operand specifier, mode in [5:3], register in [2:0] |
| req_size | input | 3 | Operand size code (0 byte, 1 word, 2 long, 3 8-byte, 4 12-byte) |
| rsp_valid | output | 1 | Classification present |
| rsp_ready | input | 1 | Downstream takes the classification |
| rsp_reg | output | 4 | Register number |
| rsp_flags | output | 8 | Mode flags, positions as in R1 |
| rsp_illegal | output | 1 | Specifier not decodable |
| rsp_ext | output | 3 | Count of 16-bit extension words |

## Verification
The block holds only one response register and its valid bit. A corrupted classification therefore shows up on the response fields in the very cycle after the request is accepted, and it persists until the response is consumed. A broken valid bit or ready path shows up as a lost response, a duplicated acceptance, or fields changing during a stall, all within one or two cycles of the stalling pattern. Each mode, every mode-7 sub-code and each immediate size are driven directly. The stall and back-to-back cases cover the holding register.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int FIELD_W = 6;
    localparam int MODE_W  = 3;
    localparam int REG_W   = 4;
    localparam int SIZE_W  = 3;
    localparam int EXT_W   = 3;
    localparam int SUB_W   = FIELD_W - MODE_W;

    typedef struct packed {
        logic pcrel;
        logic absolute;
        logic indexed;
        logic offset;
        logic predec;
        logic postinc;
        logic immed;
        logic direct;
    } ea_flags_t;

    localparam int FLAGS_W = $bits(ea_flags_t);

    typedef struct packed {
        logic [REG_W-1:0] reg_num;
        ea_flags_t        flags;
        logic             illegal;
        logic [EXT_W-1:0] ext_words;
    } ea_result_t;

    localparam int RESULT_W = $bits(ea_result_t);

    // Extension words carried by an immediate operand, per size code.
    function automatic logic [EXT_W:0] imm_words(input logic [SIZE_W-1:0] sz);
        logic [EXT_W:0] r;  // MSB marks an unusable size code
        case (sz)
            3'd0, 3'd1: r = {1'b0, 3'd1};
            3'd2:       r = {1'b0, 3'd2};
            3'd3:       r = {1'b0, 3'd4};
            3'd4:       r = {1'b0, 3'd6};
            default:    r = {1'b1, 3'd0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ea_mode_classify.sv
module ea_mode_classify
    import ea_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output logic [REG_W-1:0]   reg_num,
    output ea_flags_t          flags,
    output logic               bad_code,
    output logic               needs_imm,
    output logic [EXT_W-1:0]   fixed_ext
);
    logic [MODE_W-1:0] mode;
    logic [SUB_W-1:0]  sub;

    assign mode = field[FIELD_W-1:SUB_W];
    assign sub  = field[SUB_W-1:0];

    always_comb begin
        reg_num   = {1'b1, sub};
        flags     = '0;
        bad_code  = 1'b0;
        needs_imm = 1'b0;
        fixed_ext = '0;
        case (mode)
            3'd0, 3'd1: begin
                reg_num      = field[REG_W-1:0];
                flags.direct = 1'b1;
            end
            3'd2: ;
            3'd3: flags.postinc = 1'b1;
            3'd4: flags.predec  = 1'b1;
            3'd5: begin
                flags.offset = 1'b1;
                fixed_ext    = 3'd1;
            end
            3'd6: begin
                flags.indexed = 1'b1;
                fixed_ext     = 3'd1;
            end
            default: begin
                reg_num = {1'b0, sub};
                case (sub)
                    3'd0: begin flags.absolute = 1'b1; fixed_ext = 3'd1; end
                    3'd1: begin flags.absolute = 1'b1; fixed_ext = 3'd2; end
                    3'd2: begin
                        flags.pcrel  = 1'b1;
                        flags.offset = 1'b1;
                        fixed_ext    = 3'd1;
                    end
                    3'd3: begin
                        flags.pcrel   = 1'b1;
                        flags.indexed = 1'b1;
                        fixed_ext     = 3'd1;
                    end
                    3'd4: begin
                        flags.immed = 1'b1;
                        needs_imm   = 1'b1;
                    end
                    default: bad_code = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/ea_ext_count.sv
module ea_ext_count
    import ea_pkg::*;
(
    input  logic               needs_imm,
    input  logic [EXT_W-1:0]   fixed_ext,
    input  logic [SIZE_W-1:0]  size_code,
    output logic [EXT_W-1:0]   ext_words,
    output logic               size_bad
);
    logic [EXT_W:0] imm;

    assign imm       = imm_words(size_code);
    assign ext_words = needs_imm ? imm[EXT_W-1:0] : fixed_ext;
    assign size_bad  = needs_imm & imm[EXT_W];
endmodule

// File: rtl/ea_result_stage.sv
module ea_result_stage
    import ea_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  ea_result_t in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output ea_result_t out_data
);
    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_data  <= in_data;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R10: a stalled response keeps its value and its valid
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: an accepted request shows up as a valid response next cycle
    p_accept_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R8: an illegal response carries no flags and no words
    p_illegal_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data.illegal) |-> (out_data.flags == '0 && out_data.ext_words == '0));

    // R1: a direct response needs no extension words
    p_direct_noext_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data.flags.direct) |-> (out_data.ext_words == '0 && !out_data.illegal));

    // R2: apart from the PC-relative qualifier at most one mode flag is set
    p_single_mode_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_data.flags[FLAGS_W-2:0]));

    // R7: an accepted immediate always asks for at least one word
    p_imm_words_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data.flags.immed) |-> (out_data.ext_words != '0));
endmodule

// File: rtl/ea_field_decoder.sv
module ea_field_decoder
    import ea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [FIELD_W-1:0]   req_field,
    input  logic [SIZE_W-1:0]    req_size,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [REG_W-1:0]     rsp_reg,
    output logic [FLAGS_W-1:0]   rsp_flags,
    output logic                 rsp_illegal,
    output logic [EXT_W-1:0]     rsp_ext
);
    logic [REG_W-1:0] cls_reg;
    ea_flags_t        cls_flags;
    logic             cls_bad;
    logic             cls_imm;
    logic [EXT_W-1:0] cls_fixed;
    logic [EXT_W-1:0] cnt_ext;
    logic             cnt_bad;
    logic             is_illegal;
    ea_result_t       next_res;
    ea_result_t       held_res;

    ea_mode_classify u_classify (
        .field     (req_field),
        .reg_num   (cls_reg),
        .flags     (cls_flags),
        .bad_code  (cls_bad),
        .needs_imm (cls_imm),
        .fixed_ext (cls_fixed)
    );

    ea_ext_count u_count (
        .needs_imm (cls_imm),
        .fixed_ext (cls_fixed),
        .size_code (req_size),
        .ext_words (cnt_ext),
        .size_bad  (cnt_bad)
    );

    assign is_illegal = cls_bad | cnt_bad;

    always_comb begin
        next_res.reg_num   = cls_reg;
        next_res.illegal   = is_illegal;
        next_res.flags     = is_illegal ? '0 : cls_flags;
        next_res.ext_words = is_illegal ? '0 : cnt_ext;
    end

    ea_result_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (next_res),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (held_res)
    );

    assign rsp_reg     = held_res.reg_num;
    assign rsp_flags   = held_res.flags;
    assign rsp_illegal = held_res.illegal;
    assign rsp_ext     = held_res.ext_words;
endmodule

// File: tb/tb_ea_field_decoder.sv
module tb_ea_field_decoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_ready;
    logic [5:0] req_field;
    logic [2:0] req_size;
    logic       rsp_valid;
    logic       rsp_ready;
    logic [3:0] rsp_reg;
    logic [7:0] rsp_flags;
    logic       rsp_illegal;
    logic [2:0] rsp_ext;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_field_decoder dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_field(req_field), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_reg(rsp_reg), .rsp_flags(rsp_flags),
        .rsp_illegal(rsp_illegal), .rsp_ext(rsp_ext)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic expect_rsp(input string tag, input logic [3:0] r,
                              input logic [7:0] f, input logic ill, input logic [2:0] e);
        check(tag, "valid", 32'(rsp_valid), 32'd1);
        check(tag, "reg", 32'(rsp_reg), 32'(r));
        check(tag, "flags", 32'(rsp_flags), 32'(f));
        check(tag, "illegal", 32'(rsp_illegal), 32'(ill));
        check(tag, "ext", 32'(rsp_ext), 32'(e));
    endtask

    // Called at a falling edge; returns at the next falling edge with the result.
    task automatic send(input logic [5:0] f, input logic [2:0] s);
        req_field = f;
        req_size  = s;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R11", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R11", "req_ready after reset", 32'(req_ready), 32'd1);
    endtask

    task automatic t_direct;
        send(6'o03, 3'd2); expect_rsp("R1", 4'd3, 8'h01, 1'b0, 3'd0);
        send(6'o15, 3'd4); expect_rsp("R1", 4'd13, 8'h01, 1'b0, 3'd0);
    endtask

    task automatic t_indirect;
        send(6'o25, 3'd0); expect_rsp("R2", 4'd13, 8'h00, 1'b0, 3'd0);
        send(6'o37, 3'd2); expect_rsp("R2", 4'd15, 8'h04, 1'b0, 3'd0);
        send(6'o40, 3'd1); expect_rsp("R2", 4'd8, 8'h08, 1'b0, 3'd0);
    endtask

    task automatic t_disp_index;
        send(6'o52, 3'd2); expect_rsp("R3", 4'd10, 8'h10, 1'b0, 3'd1);
        send(6'o52, 3'd4); expect_rsp("R3", 4'd10, 8'h10, 1'b0, 3'd1);
        send(6'o66, 3'd2); expect_rsp("R4", 4'd14, 8'h20, 1'b0, 3'd1);
    endtask

    task automatic t_mode7;
        send(6'o70, 3'd2); expect_rsp("R5", 4'd0, 8'h40, 1'b0, 3'd1);
        send(6'o71, 3'd2); expect_rsp("R5", 4'd1, 8'h40, 1'b0, 3'd2);
        send(6'o72, 3'd2); expect_rsp("R6", 4'd2, 8'h90, 1'b0, 3'd1);
        send(6'o73, 3'd2); expect_rsp("R6", 4'd3, 8'hA0, 1'b0, 3'd1);
    endtask

    task automatic t_immediate;
        send(6'o74, 3'd0); expect_rsp("R7", 4'd4, 8'h02, 1'b0, 3'd1);
        send(6'o74, 3'd1); expect_rsp("R7", 4'd4, 8'h02, 1'b0, 3'd1);
        send(6'o74, 3'd2); expect_rsp("R7", 4'd4, 8'h02, 1'b0, 3'd2);
        send(6'o74, 3'd3); expect_rsp("R7", 4'd4, 8'h02, 1'b0, 3'd4);
        send(6'o74, 3'd4); expect_rsp("R7", 4'd4, 8'h02, 1'b0, 3'd6);
    endtask

    task automatic t_illegal;
        send(6'o75, 3'd2); expect_rsp("R8", 4'd5, 8'h00, 1'b1, 3'd0);
        send(6'o76, 3'd2); expect_rsp("R8", 4'd6, 8'h00, 1'b1, 3'd0);
        send(6'o77, 3'd0); expect_rsp("R8", 4'd7, 8'h00, 1'b1, 3'd0);
        send(6'o74, 3'd5); expect_rsp("R8", 4'd4, 8'h00, 1'b1, 3'd0);
    endtask

    task automatic t_back_to_back;
        req_field = 6'o71; req_size = 3'd2; req_valid = 1'b1;
        @(negedge clk);
        expect_rsp("R9", 4'd1, 8'h40, 1'b0, 3'd2);
        check("R9", "ready while consumed", 32'(req_ready), 32'd1);
        req_field = 6'o34;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R9", 4'd12, 8'h04, 1'b0, 3'd0);
        @(negedge clk);
        check("R9", "valid drops when idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_stall;
        rsp_ready = 1'b0;
        send(6'o55, 3'd2);
        expect_rsp("R10", 4'd13, 8'h10, 1'b0, 3'd1);
        check("R9", "ready low during stall", 32'(req_ready), 32'd0);
        req_field = 6'o03; req_size = 3'd0; req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            expect_rsp("R10", 4'd13, 8'h10, 1'b0, 3'd1);
            check("R10", "request refused", 32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R10", 4'd3, 8'h01, 1'b0, 3'd0);
        @(negedge clk);
        check("R10", "valid clears after take", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_field = '0; req_size = '0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_disp_index();
        t_mode7();
        t_immediate();
        t_illegal();
        t_back_to_back();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule